// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block turns single read and write requests from a host into the command steps that a four-bank DRAM device needs. It keeps one row open per bank. A request that targets the row already open in its bank goes straight to the column command. A request to a closed bank first activates the row. A request to a bank that holds a different row first closes that row with a precharge, waits, activates the new row, waits, and then issues the column command. Row and column addresses share one address bus: the row goes out with the activate and the column goes out with the read or write.

The host offers a request with a valid/ready handshake. Ready is high only while the sequencer is idle. Read data comes back as a registered word with a one-cycle valid strobe. The three waits are separate parameters: precharge-to-activate (`T_RP`), activate-to-column (`T_RCD`) and read-to-data (`T_CL`). The data word width `DQ_W` may be 4, 8, 16 or 32.

The controller is a seven-state machine:
- `ST_IDLE` accepts a request and moves to `ST_COL` on a row hit, to `ST_ACT` on a closed bank, or to `ST_PRE` on a row conflict.
- `ST_PRE` moves to `ST_WAIT_RP`, or straight to `ST_ACT` when `T_RP` is 1.
- `ST_WAIT_RP` moves to `ST_ACT` when its timer expires.
- `ST_ACT` moves to `ST_WAIT_RCD`, or straight to `ST_COL` when `T_RCD` is 1.
- `ST_WAIT_RCD` moves to `ST_COL` when its timer expires.
- `ST_COL` returns to `ST_IDLE` after a write and goes to `ST_WAIT_CL` after a read.
- `ST_WAIT_CL` captures the data and returns to `ST_IDLE` when its timer expires.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `dram_cmd` is NOP, and every bank is closed, so the first request to any bank begins with an activate and never with a precharge.
- R2: A request to a closed bank issues ACT with the row on `dram_addr` in the cycle after acceptance. The column command follows exactly `T_RCD` cycles after the ACT, with the column zero-extended on `dram_addr`.
- R3: A request whose row equals the row open in its bank issues its RD or WR in the cycle after acceptance, with no ACT and no PRE before it.
- R4: A request to a bank holding a different row issues PRE in the cycle after acceptance, then ACT exactly `T_RP` cycles later, then the column command exactly `T_RCD` cycles after the ACT. An ACT is never issued to a bank that is already open.
- R5: For a read, `rsp_valid` is high for exactly one cycle, `T_CL`+1 cycles after the RD. `rsp_rdata` then holds the value that `dram_rdata` had `T_CL` cycles after the RD.
- R6: A WR command drives the request's write data on `dram_wdata` and returns no response. A write leaves its row open, so a later request to the same row goes straight to the column command.
- R7: `req_ready` falls in the cycle after acceptance and stays low until the sequence ends: the cycle after a WR, or the response cycle of a read. A request held valid while ready is low is ignored and changes no command or address.
- R8: Each bank keeps its own open row. An access to one bank does not change which row another bank holds open.
- R9: At most one command is issued per cycle, with the encoding NOP=0, ACT=1, RD=2, WR=3, PRE=4. Every cycle that carries no step of the sequence shows NOP, and `dram_bank` names the target bank on every non-NOP command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_bank | input | BW (2) | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_wdata | input | DQ_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DQ_W | Read data |
| dram_cmd | output | 3 | Command code (NOP/ACT/RD/WR/PRE) |
| dram_bank | output | BW (2) | Bank of the current command |
| dram_addr | output | AW | Shared row/column address |
| dram_wdata | output | DQ_W | Data carried with WR |
| dram_rdata | input | DQ_W | Data returned by the device |

## Verification
The hardest case to reach from the ports is a row conflict in a bank that is open while other banks hold rows of their own. Reaching it needs a history of earlier accesses to several banks. The random stimulus therefore draws rows from a set of only four values and banks from all four, which makes hits, closed-bank activates and conflicts all frequent. Directed requests before the random run open two banks and then cross between them. During some sequences the bench keeps `req_valid` high with unrelated fields, so that a request offered while busy must leave every command and address unchanged.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } dram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_WAIT_RP,
        ST_ACT,
        ST_WAIT_RCD,
        ST_COL,
        ST_WAIT_CL
    } seq_state_e;

endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == CW'(1));
endmodule

// File: rtl/bank_row_table.sv
module bank_row_table #(
    parameter int NB    = 4,
    parameter int ROW_W = 12,
    localparam int BW   = $clog2(NB)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      open_en,
    input  logic                      close_en,
    input  logic [BW-1:0]             sel_bank,
    input  logic [ROW_W-1:0]          sel_row,
    output logic [NB-1:0]             open_vec,
    output logic [NB-1:0][ROW_W-1:0]  row_vec
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_vec[b] <= 1'b0;
                row_vec[b]  <= '0;
            end else if (sel_bank == BW'(b)) begin
                if (open_en) begin
                    open_vec[b] <= 1'b1;
                    row_vec[b]  <= sel_row;
                end else if (close_en) begin
                    open_vec[b] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
    import dram_seq_pkg::*;
#(
    parameter int NB    = 4,
    parameter int ROW_W = 12,
    parameter int COL_W = 8,
    parameter int DQ_W  = 16,
    parameter int T_RP  = 2,
    parameter int T_RCD = 3,
    parameter int T_CL  = 2,
    localparam int BW   = $clog2(NB),
    localparam int AW   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BW-1:0]     req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rsp_valid,
    output logic [DQ_W-1:0]   rsp_rdata,
    output logic [2:0]        dram_cmd,
    output logic [BW-1:0]     dram_bank,
    output logic [AW-1:0]     dram_addr,
    output logic [DQ_W-1:0]   dram_wdata,
    input  logic [DQ_W-1:0]   dram_rdata
);
    localparam int MAXD = (T_RP > T_RCD) ? ((T_RP > T_CL) ? T_RP : T_CL)
                                         : ((T_RCD > T_CL) ? T_RCD : T_CL);
    localparam int CW   = $clog2(MAXD + 1) + 1;

    seq_state_e state, nxt;

    logic [BW-1:0]            lat_bank;
    logic [ROW_W-1:0]         lat_row;
    logic [COL_W-1:0]         lat_col;
    logic                     lat_wr;
    logic [DQ_W-1:0]          lat_wdata;
    logic                     accept;
    logic [NB-1:0]            bank_open;
    logic [NB-1:0][ROW_W-1:0] bank_row;
    logic                     tmr_load;
    logic [CW-1:0]            tmr_val;
    logic                     tmr_exp;
    logic                     req_hit_open;
    logic                     req_row_same;

    assign accept       = req_valid && req_ready;
    assign req_hit_open = bank_open[req_bank];
    assign req_row_same = (bank_row[req_bank] == req_row);

    bank_row_table #(.NB(NB), .ROW_W(ROW_W)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_en  (state == ST_ACT),
        .close_en (state == ST_PRE),
        .sel_bank (lat_bank),
        .sel_row  (lat_row),
        .open_vec (bank_open),
        .row_vec  (bank_row)
    );

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_PRE: begin tmr_load = 1'b1; tmr_val = CW'(T_RP - 1);  end
            ST_ACT: begin tmr_load = 1'b1; tmr_val = CW'(T_RCD - 1); end
            ST_COL: begin tmr_load = 1'b1; tmr_val = CW'(T_CL);      end
            default: ;
        endcase
    end

    seq_wait_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_exp)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_bank  <= '0;
            lat_row   <= '0;
            lat_col   <= '0;
            lat_wr    <= 1'b0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_bank  <= req_bank;
            lat_row   <= req_row;
            lat_col   <= req_col;
            lat_wr    <= req_write;
            lat_wdata <= req_wdata;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (req_hit_open && req_row_same) nxt = ST_COL;
                    else if (req_hit_open)            nxt = ST_PRE;
                    else                              nxt = ST_ACT;
                end
            end
            ST_PRE:      nxt = (T_RP > 1) ? ST_WAIT_RP : ST_ACT;
            ST_WAIT_RP:  if (tmr_exp) nxt = ST_ACT;
            ST_ACT:      nxt = (T_RCD > 1) ? ST_WAIT_RCD : ST_COL;
            ST_WAIT_RCD: if (tmr_exp) nxt = ST_COL;
            ST_COL:      nxt = lat_wr ? ST_IDLE : ST_WAIT_CL;
            ST_WAIT_CL:  if (tmr_exp) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dram_cmd   = CMD_NOP;
        dram_bank  = lat_bank;
        dram_addr  = '0;
        dram_wdata = lat_wdata;
        req_ready  = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_PRE:  dram_cmd  = CMD_PRE;
            ST_ACT: begin
                dram_cmd              = CMD_ACT;
                dram_addr[ROW_W-1:0]  = lat_row;
            end
            ST_COL: begin
                dram_cmd              = lat_wr ? CMD_WR : CMD_RD;
                dram_addr[COL_W-1:0]  = lat_col;
            end
            default: ;
        endcase
    end

    // read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state == ST_WAIT_CL) && tmr_exp;
            if ((state == ST_WAIT_CL) && tmr_exp)
                rsp_rdata <= dram_rdata;
        end
    end
endmodule

// File: rtl/dram_bank_seq_chk.sv
module dram_bank_seq_chk #(
    parameter int NB = 4,
    localparam int BW = $clog2(NB)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [2:0]    dram_cmd,
    input logic [BW-1:0] dram_bank,
    input logic [NB-1:0] bank_open
);
    // R9
    legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_cmd <= 3'd4);

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4
    act_on_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cmd == 3'd1) |-> !bank_open[dram_bank]);

    // R2
    col_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cmd == 3'd2 || dram_cmd == 3'd3) |-> bank_open[dram_bank]);

    // R6
    write_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cmd == 3'd3) |=> (req_ready && !rsp_valid));
endmodule

bind dram_bank_seq dram_bank_seq_chk #(.NB(NB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .dram_cmd  (dram_cmd),
    .dram_bank (dram_bank),
    .bank_open (bank_open)
);

// File: tb/tb_dram_bank_seq.sv
module tb_dram_bank_seq;
    localparam int NB = 4, BW = 2, ROW_W = 12, COL_W = 8, DQ_W = 16;
    localparam int T_RP = 2, T_RCD = 3, T_CL = 2;
    localparam int AW = 12;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [BW-1:0] req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [DQ_W-1:0] req_wdata = '0, dram_rdata = '0;
    logic req_ready, rsp_valid;
    logic [DQ_W-1:0] rsp_rdata, dram_wdata;
    logic [2:0] dram_cmd;
    logic [BW-1:0] dram_bank;
    logic [AW-1:0] dram_addr;

    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 0;
    bit bm_open [NB];
    int bm_row [NB];
    int cur_bank, cur_row, cur_col;
    int rd_pend = 0;
    logic [DQ_W-1:0] rd_val;

    always #2.5 clk = ~clk;

    dram_bank_seq #(.NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
        .T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .dram_cmd(dram_cmd), .dram_bank(dram_bank),
        .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata));

    function automatic logic [DQ_W-1:0] pat(int b, int r, int c);
        return DQ_W'(b * 16'h1111) ^ DQ_W'(r * 16'h0101) ^ DQ_W'(c * 16'h0013) ^ 16'hA5C3;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // device model: data appears T_CL cycles after RD
    always @(negedge clk) begin
        if (rd_pend > 0) begin
            rd_pend = rd_pend - 1;
            dram_rdata = (rd_pend == 0) ? rd_val : DQ_W'($urandom);
        end else begin
            dram_rdata = DQ_W'($urandom);
        end
        if (dram_cmd == 3'd2) begin
            rd_pend = T_CL;
            rd_val = pat(cur_bank, cur_row, cur_col);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            nfail++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic run_req(int b, int r, int c, bit wr, logic [DQ_W-1:0] wd,
                           bit junk, string ovr);
        bit do_pre, do_act;
        int off_pre, off_act, off_col, e;
        string t;
        logic [2:0] expc;
        logic [AW-1:0] ea;
        chk(req_ready == 1'b1, "R7 idle", req_ready, 1);
        req_valid = 1; req_bank = BW'(b); req_row = ROW_W'(r);
        req_col = COL_W'(c); req_write = wr; req_wdata = wd;
        cur_bank = b; cur_row = r; cur_col = c;
        do_pre = bm_open[b] && (bm_row[b] != r);
        do_act = !bm_open[b] || do_pre;
        off_pre = 0;
        off_act = do_pre ? T_RP : 0;
        off_col = do_act ? off_act + T_RCD : 0;
        t = do_pre ? "R4" : (do_act ? "R2" : "R3");
        if (ovr != "") t = ovr;
        bm_open[b] = 1; bm_row[b] = r;
        e = wr ? off_col + 1 : off_col + T_CL + 1;
        @(negedge clk);
        if (junk) begin
            req_bank = BW'($urandom); req_row = ROW_W'($urandom);
            req_col = COL_W'($urandom); req_write = 1'($urandom);
            req_wdata = DQ_W'($urandom);
        end else req_valid = 0;
        for (int off = 0; off <= e; off++) begin
            if (do_pre && off == off_pre)      expc = 3'd4;
            else if (do_act && off == off_act) expc = 3'd1;
            else if (off == off_col)           expc = wr ? 3'd3 : 3'd2;
            else                               expc = 3'd0;
            chk(dram_cmd == expc, (expc == 3'd0) ? "R9" : t, dram_cmd, expc);
            if (expc != 3'd0)
                chk(dram_bank == BW'(b), "R9 bank", dram_bank, b);
            if (expc == 3'd1) begin
                ea = AW'(r);
                chk(dram_addr == ea, t, dram_addr, ea);
            end
            if (expc == 3'd2 || expc == 3'd3) begin
                ea = AW'(c);
                chk(dram_addr == ea, t, dram_addr, ea);
            end
            if (expc == 3'd3) chk(dram_wdata == wd, "R6", dram_wdata, wd);
            chk(req_ready == (off == e), "R7", req_ready, (off == e));
            chk(rsp_valid == (!wr && off == e), "R5", rsp_valid, (!wr && off == e));
            if (!wr && off == e)
                chk(rsp_rdata == pat(b, r, c), "R5 data", rsp_rdata, pat(b, r, c));
            if (off == e) req_valid = 0;
            else @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NB; i++) begin bm_open[i] = 0; bm_row[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(dram_cmd == 3'd0, "R1 cmd", dram_cmd, 0);
        chk(rsp_valid == 1'b0, "R1 rsp", rsp_valid, 0);
        run_req(0, 5, 3, 0, '0, 0, "R1");          // first access: ACT, no PRE
        run_req(0, 5, 7, 0, '0, 0, "R3");          // open row hit
        run_req(0, 5, 1, 1, 16'hBEEF, 0, "R3");     // write hit
        run_req(0, 5, 1, 0, '0, 0, "R6");          // row stays open after write
        run_req(1, 9, 200, 0, '0, 0, "R2");        // closed bank
        run_req(0, 5, 9, 0, '0, 0, "R8");          // bank0 unaffected by bank1
        run_req(0, 6, 4, 0, '0, 0, "R4");          // row conflict
        run_req(1, 9, 2, 1, 16'h1234, 0, "R8");     // bank1 still open
        run_req(2, 0, 255, 0, '0, 1, "R7");         // busy while valid held
        run_req(2, 1, 0, 1, 16'h0F0F, 1, "R7");
        for (int n = 0; n < 400; n++)
            run_req(int'($urandom % NB), int'($urandom % 4), int'($urandom % 256),
                    1'($urandom), DQ_W'($urandom), 1'($urandom), "");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule